// File: doc/BRIEF.md
# Option-Register Memory Map Decoder

This block keeps a few byte-wide option registers and a set of RAM region enables. An I/O port interface writes them in the window 0x100 to 0x107. From those registers it decodes, for every physical byte address on a 24-bit bus, where a read goes and where a write goes. A read can go to on-board RAM, to the external bus, or nowhere. The same three choices apply to a write. The decode is purely combinational, so it can sit directly in the memory request path.

The address space has three overlapping parts. System RAM is divided into 1 MB regions, and option bits switch each region on. The top 128 KB below 1 MB is a window that holds either the external ROM or a shadow copy in RAM. A remap window starts at the installed memory size and relocates RAM there. Two option bits are OR-ed together to choose both the ROM source and the size of the remap window. Until software sets the configured flag, the whole map is left on the external bus.

Top module: `pos_memmap_decoder`

## Requirements
- R1: After reset, option register A reads 0x00 and option register B reads 0x30, and every region enable is clear. The decode is therefore the unconfigured map of R4.
- R2: A write to port 0x103 loads option register A, and a write to port 0x105 loads option register B. The decode follows the new value from the next clock edge on. Writes to any other port in the window, apart from 0x104, leave the decode unchanged.
- R3: A write to port 0x104 copies data bits [3:0] into the enable group chosen by B[2:0]. Group 0 holds regions 0 to 3 and group 1 holds regions 4 to 7. A selector of 2 to 7 has no effect on the decode.
- R4: While B bit 3 is 0, every address outside 0xE0000–0xFFFFF decodes as external for both read and write. Inside that window, reads go to external and writes are blocked.
- R5: While B bit 3 is 1, region k (k = 0..7) covers k MB up to k+1 MB. Enable bit k % 4 of group k / 4 turns it on. Region 0 covers only its lowest 640 KB. An enabled region decodes as internal read and write, and every other address defaults to external.
- R6: Writes to 0xE0000–0xFFFFF are always blocked, in every configuration.
- R7: Once configured, reads in 0xE0000–0xFFFFF go to external whenever B bit 0 or B bit 4 is set.
- R8: Once configured, with B bits 0 and 4 both clear, reads in 0xE0000–0xFFFFF go to internal RAM only if all three of these hold: A bit 0 is 1, B bit 5 is 0, and region 0 is enabled. Otherwise those reads are disabled.
- R9: The remap window starts at mem_kb × 1024. It is 384 KB long when B bit 0 or bit 4 is set, and 256 KB long otherwise. When the block is configured, A bit 0 is 1 and B bit 5 is 0, the window decodes as internal read and write and overrides every other rule.
- R10: Target codes on rd_tgt and wr_tgt are 00 for external, 01 for internal and 10 for disabled. The code 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | I/O port address |
| io_data | input | 8 | I/O write data |
| mem_kb | input | 15 | Installed memory size in KB (static) |
| addr | input | 24 | Physical byte address to decode |
| rd_tgt | output | 2 | Read target code |
| wr_tgt | output | 2 | Write target code |

## Verification
The bench uses the default parameters: a 24-bit address, two enable groups of four 1 MB regions, and the port window at 0x100. It holds mem_kb at 4096, which places the remap window on top of region 4. That overlap lets the bench test remap priority against both an enabled region and a disabled one. With a 24-bit address it can also probe addresses above the eight regions, up to 0xFFFFFF. The probe points sit on every boundary: the 640 KB limit, the edges of the ROM window, and both the 256 KB and 384 KB ends of the remap window.

// File: rtl/pos_memmap_decoder.sv
module pos_memmap_decoder #(
  parameter int ADDR_W     = 24,
  parameter int IO_W       = 16,
  parameter int KB_W       = 15,
  parameter int NGRP       = 2,
  parameter int IO_BASE    = 'h100,
  parameter int ROM_BASE   = 'hE0000,
  parameter int ROM_BYTES  = 'h20000,
  parameter int REGION_LOG = 20,
  parameter int LOW_KB     = 640,
  parameter int REMAP_SM   = 256,
  parameter int REMAP_LG   = 384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [IO_W-1:0]   io_addr,
  input  logic [7:0]        io_data,
  input  logic [KB_W-1:0]   mem_kb,
  input  logic [ADDR_W-1:0] addr,
  output logic [1:0]        rd_tgt,
  output logic [1:0]        wr_tgt
);
  localparam int NREG   = NGRP * 4;
  localparam int RIDX_W = ADDR_W - REGION_LOG;
  localparam int RIDX_N = 2 ** RIDX_W;
  localparam int AKB_W  = ADDR_W - 10;
  localparam logic [1:0] T_EXT = 2'b00, T_INT = 2'b01, T_DIS = 2'b10;
  localparam logic [ADDR_W-1:0] ROM_LO = ADDR_W'(ROM_BASE);
  localparam logic [ADDR_W-1:0] ROM_HI = ADDR_W'(ROM_BASE + ROM_BYTES - 1);

  logic [7:0]      opt_a, opt_b;
  logic [NREG-1:0] reg_en;

  wire hit_a   = io_wr && (io_addr == IO_W'(IO_BASE + 3));
  wire hit_grp = io_wr && (io_addr == IO_W'(IO_BASE + 4));
  wire hit_b   = io_wr && (io_addr == IO_W'(IO_BASE + 5));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_a  <= 8'h00;
      opt_b  <= 8'h30;
      reg_en <= '0;
    end else begin
      if (hit_a) opt_a <= io_data;
      if (hit_b) opt_b <= io_data;
      if (hit_grp && (int'(opt_b[2:0]) < NGRP))
        reg_en[int'(opt_b[2:0])*4 +: 4] <= io_data[3:0];
    end
  end

  wire cfg       = opt_b[3];
  wire big       = opt_b[0] | opt_b[4];
  wire remap_on  = cfg && opt_a[0] && !opt_b[5];
  wire shadow_ok = opt_a[0] && !opt_b[5] && reg_en[0];

  wire [RIDX_W-1:0] ridx   = addr[ADDR_W-1:REGION_LOG];
  wire [AKB_W-1:0]  akb    = addr[ADDR_W-1:10];
  wire [RIDX_N-1:0] en_all = RIDX_N'(reg_en);
  wire in_low  = (ridx != '0) || (akb < AKB_W'(LOW_KB));
  wire in_reg  = en_all[ridx] && in_low;
  wire in_rom  = (addr >= ROM_LO) && (addr <= ROM_HI);

  wire [KB_W:0] kb_x   = (KB_W+1)'(akb);
  wire [KB_W:0] rm_lo  = {1'b0, mem_kb};
  wire [KB_W:0] rm_hi  = rm_lo + (big ? (KB_W+1)'(REMAP_LG) : (KB_W+1)'(REMAP_SM));
  wire in_remap = (kb_x >= rm_lo) && (kb_x < rm_hi);

  always_comb begin
    rd_tgt = T_EXT;
    wr_tgt = T_EXT;
    if (cfg && in_reg) begin
      rd_tgt = T_INT;
      wr_tgt = T_INT;
    end
    if (in_rom) begin
      wr_tgt = T_DIS;
      if (!cfg || big)    rd_tgt = T_EXT;
      else if (shadow_ok) rd_tgt = T_INT;
      else                rd_tgt = T_DIS;
    end
    if (remap_on && in_remap) begin
      rd_tgt = T_INT;
      wr_tgt = T_INT;
    end
  end
endmodule

// File: rtl/pos_memmap_decoder_chk.sv
module pos_memmap_decoder_chk #(
  parameter int ADDR_W    = 24,
  parameter int IO_W      = 16,
  parameter int NREG      = 8,
  parameter int NGRP      = 2,
  parameter int IO_BASE   = 'h100,
  parameter int ROM_BASE  = 'hE0000,
  parameter int ROM_BYTES = 'h20000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_wr,
  input logic [IO_W-1:0]   io_addr,
  input logic [7:0]        io_data,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        rd_tgt,
  input logic [1:0]        wr_tgt,
  input logic [7:0]        opt_b,
  input logic [NREG-1:0]   reg_en
);
  wire rom_hit = (int'(addr) >= ROM_BASE) && (int'(addr) < ROM_BASE + ROM_BYTES);

  assert_rom_wr_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rom_hit |-> wr_tgt == 2'b10);

  assert_unconfigured_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!opt_b[3] && !rom_hit) |-> (rd_tgt == 2'b00 && wr_tgt == 2'b00));

  assert_optb_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == IO_W'(IO_BASE + 5)) |=> opt_b == $past(io_data));

  assert_bad_sel_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == IO_W'(IO_BASE + 4) && int'(opt_b[2:0]) >= NGRP) |=> $stable(reg_en));

  assert_rom_ext_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_hit && opt_b[3] && (opt_b[0] || opt_b[4])) |-> rd_tgt == 2'b00);

  assert_legal_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_tgt != 2'b11 && wr_tgt != 2'b11);
endmodule

bind pos_memmap_decoder pos_memmap_decoder_chk #(
  .ADDR_W(ADDR_W), .IO_W(IO_W), .NREG(NGRP*4), .NGRP(NGRP), .IO_BASE(IO_BASE),
  .ROM_BASE(ROM_BASE), .ROM_BYTES(ROM_BYTES)
) chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data),
  .addr(addr), .rd_tgt(rd_tgt), .wr_tgt(wr_tgt), .opt_b(opt_b), .reg_en(reg_en)
);

// File: tb/pos_memmap_decoder_test.sv
module pos_memmap_decoder_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_wr = 0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_data = '0;
  logic [14:0] mem_kb = 15'd4096;
  logic [23:0] addr = '0;
  logic [1:0]  rd_tgt, wr_tgt;

  int compared = 0, mismatched = 0;
  bit done = 0;

  pos_memmap_decoder uut (.clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_data(io_data), .mem_kb(mem_kb), .addr(addr), .rd_tgt(rd_tgt), .wr_tgt(wr_tgt));

  always #10 clk = ~clk;

  // reference state
  int m_a, m_b;
  bit m_en[8];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a = 0; m_b = 'h30;
      foreach (m_en[i]) m_en[i] = 0;
    end else if (io_wr) begin
      if (io_addr == 'h103) m_a = io_data;
      else if (io_addr == 'h105) m_b = io_data;
      else if (io_addr == 'h104 && (m_b % 8) < 2)
        for (int j = 0; j < 4; j++) m_en[(m_b % 8) * 4 + j] = io_data[j];
    end
  end

  // R10 codes: 0 external, 1 internal, 2 disabled
  function automatic void model(input int a, output int r, output int w, output string tag);
    int kb = a / 1024;
    bit cfg = m_b[3];
    bit big = m_b[0] || m_b[4];
    int rsz = big ? 384 : 256;
    r = 0; w = 0; tag = cfg ? "R5" : "R4";
    if (cfg) begin
      int k = a / (1 << 20);
      if (k < 8 && m_en[k] && !(k == 0 && kb >= 640)) begin r = 1; w = 1; end
    end
    if (kb >= 896 && kb < 1024) begin
      w = 2;
      if (!cfg) begin r = 0; tag = "R6/R4"; end
      else if (big) begin r = 0; tag = "R6/R7"; end
      else begin
        tag = "R6/R8";
        r = (m_a[0] && !m_b[5] && m_en[0]) ? 1 : 2;
      end
    end
    if (cfg && m_a[0] && !m_b[5] && kb >= int'(mem_kb) && kb < int'(mem_kb) + rsz) begin
      r = 1; w = 1; tag = "R9";
    end
  endfunction

  task automatic check();
    int er, ew; string tag;
    model(int'(addr), er, ew, tag);
    if (!rst_n) tag = "R1";
    compared++;
    if (rd_tgt !== 2'(er) || wr_tgt !== 2'(ew)) begin
      mismatched++;
      $display("FAIL %s addr=%h rd=%0d exp %0d wr=%0d exp %0d", tag, addr, rd_tgt, er, wr_tgt, ew);
    end
  endtask

  task automatic tick(input logic [23:0] a, input bit w = 0, input int port = 0, input int d = 0);
    @(negedge clk);
    check();
    addr = a; io_wr = w; io_addr = 16'(port); io_data = 8'(d);
  endtask

  task automatic pwr(input int port, input int d);
    tick(addr, 1, port, d);
    tick(addr);
  endtask

  int probes[19] = '{'h000000, 'h09FFFF, 'h0A0000, 'h0DFFFF, 'h0E0000, 'h0FFFFF,
                     'h100000, 'h200000, 'h300000, 'h3FFFFF, 'h400000, 'h43FFFF,
                     'h440000, 'h45FFFF, 'h460000, 'h500000, 'h700000, 'h800000, 'hFFFFFF};

  task automatic sweep();
    foreach (probes[i]) tick(24'(probes[i]));
    tick(24'h0);
  endtask

  initial begin
    tick(24'h0E0000); tick(24'h000000); tick(24'h400000);   // R1 during reset
    rst_n = 1;
    sweep();                                       // R1, R4
    pwr('h103, 'h01);                              // R2
    pwr('h105, 'h00); pwr('h104, 'hF5);            // R3 group 0
    pwr('h105, 'h01); pwr('h104, 'h0A);            // R3 group 1
    pwr('h105, 'h08); sweep();                     // R5, R8, R9 small
    pwr('h105, 'h28); sweep();                     // R8 disabled, R9 off
    pwr('h105, 'h18); sweep();                     // R7, R9 large
    pwr('h105, 'h09); pwr('h104, 'h03); sweep();   // R7 via bit 0, R3
    pwr('h105, 'h0D); pwr('h104, 'h0F);            // R3 ignored selector
    pwr('h106, 'hFF); pwr('h100, 'h00); sweep();   // R2 other ports ignored
    pwr('h105, 'h08); pwr('h104, 'h04); sweep();   // R8 region 0 off
    pwr('h103, 'h00); sweep();                     // R9 off, R8 disabled
    pwr('h105, 'h00); sweep();                     // R4 again
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule